// File: doc/BRIEF.md
# Calendar Alarm Match Interrupt

This block watches the running calendar of a real-time clock and raises an interrupt when the current time agrees with a programmed alarm pattern. The pattern holds year, month, day of month, day of week, hour, minute and second. Each of these seven fields has its own compare-enable bit. A field whose bit is clear counts as matching whatever its value is. A single arm bit gates the whole comparator. While the comparator is armed, the pattern and the compare-enable mask are frozen.

The comparison result is registered as a raw interrupt. An interrupt-enable bit and an interrupt-force bit then shape the registered output line, which is the raw bit ANDed with the enable and ORed with the force. Software programs the block through a simple write port, made of a strobe, a selector and a data word. The live time fields arrive from the calendar counter as plain inputs.

Top module: `cal_alarm_irq`

## Requirements
- R1: After reset, match_active_o, irq_raw_o and irq_o are low. The pattern, mask, arm, interrupt-enable and force registers are all cleared.
- R2: A write with selector 3 loads bit 0 of the data into the arm bit. match_active_o follows the arm bit one clock after the write is sampled, both when it rises and when it falls.
- R3: irq_raw_o is registered. One clock after the inputs are sampled, it is high exactly when the block is armed and every enabled field equals the live value.
- R4: The mask is written with selector 2, one bit per field: bit 0 second, bit 1 minute, bit 2 hour, bit 3 day of week, bit 4 day, bit 5 month, bit 6 year. A field whose bit is clear is ignored in the comparison.
- R5: When the block is armed and the mask is all zero, irq_raw_o stays high continuously.
- R6: While the block is armed, writes with selectors 0, 1 and 2 are ignored. They take effect normally when the block is disarmed.
- R7: irq_o is registered. One clock after its inputs, it equals (raw AND enable) OR force. The enable is bit 0 of a selector-4 write and the force is bit 0 of a selector-5 write, and both may be written at any time.
- R8: While the block is disarmed, irq_raw_o is low even if every field matches.
- R9: Selector 0 loads the date pattern: day in data[4:0], month in data[11:8], year in data[27:16]. Selector 1 loads the time pattern: hour in data[4:0], minute in data[13:8], second in data[21:16], day of week in data[26:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| now_year_i | input | 12 | Live year |
| now_month_i | input | 4 | Live month |
| now_day_i | input | 5 | Live day of month |
| now_wday_i | input | 3 | Live day of week |
| now_hour_i | input | 5 | Live hour |
| now_min_i | input | 6 | Live minute |
| now_sec_i | input | 6 | Live second |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register selector |
| wr_data_i | input | 32 | Write data |
| match_active_o | output | 1 | Comparator armed status |
| irq_raw_o | output | 1 | Raw match interrupt |
| irq_o | output | 1 | Masked and forced interrupt line |

## Verification
The comparator is first driven with a live time equal to a pattern that has distinct values in every field, with all enables set. It is then driven with a single second that differs, which separates a full compare from a partial one.

For each of the seven fields, the bench applies a live time that differs in that field alone, under two masks. One mask enables only that field and the other enables every field except it. A wrong bit position, or a field that is compared while it should be ignored, shows up as a mismatch in one of the two.

Further stimulus covers three cases: writes to the pattern and mask while armed, which must stay invisible at irq_raw_o; an empty mask; and separate enable and force writes, which show the cycle at which each one reaches irq_o.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

  localparam int YEAR_W     = 12;
  localparam int MON_W      = 4;
  localparam int DAY_W      = 5;
  localparam int WDAY_W     = 3;
  localparam int HOUR_W     = 5;
  localparam int MIN_W      = 6;
  localparam int SEC_W      = 6;
  localparam int NUM_FIELDS = 7;
  localparam int SEL_W      = 3;

  // bit positions inside the write data words
  localparam int DATE_DAY_LSB  = 0;
  localparam int DATE_MON_LSB  = 8;
  localparam int DATE_YEAR_LSB = 16;
  localparam int TIME_HOUR_LSB = 0;
  localparam int TIME_MIN_LSB  = 8;
  localparam int TIME_SEC_LSB  = 16;
  localparam int TIME_WDAY_LSB = 24;

  // second is the least significant field, year the most significant
  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  month;
    logic [DAY_W-1:0]  day;
    logic [WDAY_W-1:0] wday;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } cal_time_t;

  localparam int TIME_W = $bits(cal_time_t);

  typedef enum logic [SEL_W-1:0] {
    SEL_DATE = 3'd0,
    SEL_TIME = 3'd1,
    SEL_MASK = 3'd2,
    SEL_ARM  = 3'd3,
    SEL_IEN  = 3'd4,
    SEL_FRC  = 3'd5
  } wr_sel_e;

  // width of field i, with field 0 being the second
  function automatic int fld_w(input int i);
    case (i)
      0: return SEC_W;
      1: return MIN_W;
      2: return HOUR_W;
      3: return WDAY_W;
      4: return DAY_W;
      5: return MON_W;
      6: return YEAR_W;
      default: return 0;
    endcase
  endfunction

  // lsb position of field i inside the packed time word
  function automatic int fld_off(input int i);
    int s;
    s = 0;
    for (int k = 0; k < i; k++) s += fld_w(k);
    return s;
  endfunction

endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [DATA_W-1:0]     wr_data,
  output cal_time_t             pattern,
  output logic [NUM_FIELDS-1:0] fmask,
  output logic                  arm,
  output logic                  ien,
  output logic                  frc
);

  cal_time_t             pat_q, pat_d;
  logic [NUM_FIELDS-1:0] mask_q, mask_d;
  logic                  arm_q, ien_q, frc_q;
  logic                  date_we, time_we, mask_we, arm_we, ien_we, frc_we;
  logic                  unused_bits;

  assign unused_bits = ^wr_data;

  // write enables; pattern and mask are locked while armed
  always_comb begin
    date_we = wr_en && (wr_sel == SEL_DATE) && !arm_q;
    time_we = wr_en && (wr_sel == SEL_TIME) && !arm_q;
    mask_we = wr_en && (wr_sel == SEL_MASK) && !arm_q;
    arm_we  = wr_en && (wr_sel == SEL_ARM);
    ien_we  = wr_en && (wr_sel == SEL_IEN);
    frc_we  = wr_en && (wr_sel == SEL_FRC);
  end

  always_comb begin
    pat_d = pat_q;
    if (date_we) begin
      pat_d.day   = wr_data[DATE_DAY_LSB  +: DAY_W];
      pat_d.month = wr_data[DATE_MON_LSB  +: MON_W];
      pat_d.year  = wr_data[DATE_YEAR_LSB +: YEAR_W];
    end
    if (time_we) begin
      pat_d.hour = wr_data[TIME_HOUR_LSB +: HOUR_W];
      pat_d.min  = wr_data[TIME_MIN_LSB  +: MIN_W];
      pat_d.sec  = wr_data[TIME_SEC_LSB  +: SEC_W];
      pat_d.wday = wr_data[TIME_WDAY_LSB +: WDAY_W];
    end
    mask_d = wr_data[NUM_FIELDS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q  <= '0;
      mask_q <= '0;
      arm_q  <= 1'b0;
      ien_q  <= 1'b0;
      frc_q  <= 1'b0;
    end else begin
      if (date_we || time_we) pat_q  <= pat_d;
      if (mask_we)            mask_q <= mask_d;
      if (arm_we)             arm_q  <= wr_data[0];
      if (ien_we)             ien_q  <= wr_data[0];
      if (frc_we)             frc_q  <= wr_data[0];
    end
  end

  assign pattern = pat_q;
  assign fmask   = mask_q;
  assign arm     = arm_q;
  assign ien     = ien_q;
  assign frc     = frc_q;

  // R6: nothing in the pattern or mask moves while armed
  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |=> ($stable(pat_q) && $stable(mask_q)));

  // R2: arm follows a selector-3 write one clock later
  p_arm_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_ARM && wr_data[0]) |=> arm_q);

  p_arm_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_ARM && !wr_data[0]) |=> !arm_q);

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  cal_time_t             live,
  input  cal_time_t             pattern,
  input  logic [NUM_FIELDS-1:0] fmask,
  input  logic                  arm,
  output logic                  raw
);

  logic [TIME_W-1:0]     live_flat, pat_flat;
  logic [NUM_FIELDS-1:0] fld_ok;
  logic                  raw_d, raw_q;

  assign live_flat = live;
  assign pat_flat  = pattern;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam int W = fld_w(g);
    localparam int O = fld_off(g);
    assign fld_ok[g] = !fmask[g] || (live_flat[O +: W] == pat_flat[O +: W]);
  end

  always_comb raw_d = arm && (&fld_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= raw_d;
  end

  assign raw = raw_q;

  // R8: disarmed comparator never reports
  p_raw_disarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !raw_q);

  // R5: empty mask while armed matches unconditionally
  p_raw_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && fmask == '0) |=> raw_q);

  // R3: a full-field equality while armed reports next cycle
  p_raw_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && live == pattern) |=> raw_q);

endmodule

// File: rtl/cal_alarm_irq_out.sv
module cal_alarm_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic ien,
  input  logic frc,
  output logic irq
);

  logic irq_d, irq_q;

  always_comb irq_d = (raw && ien) || frc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R7: force drives the line regardless of raw
  p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frc |=> irq_q);

  // R7: with enable and force clear the line stays quiet
  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien && !frc) |=> !irq_q);

endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq
  import cal_alarm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [YEAR_W-1:0]     now_year_i,
  input  logic [MON_W-1:0]      now_month_i,
  input  logic [DAY_W-1:0]      now_day_i,
  input  logic [WDAY_W-1:0]     now_wday_i,
  input  logic [HOUR_W-1:0]     now_hour_i,
  input  logic [MIN_W-1:0]      now_min_i,
  input  logic [SEC_W-1:0]      now_sec_i,
  input  logic                  wr_en_i,
  input  logic [SEL_W-1:0]      wr_sel_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic                  match_active_o,
  output logic                  irq_raw_o,
  output logic                  irq_o
);

  logic [1:0]            rst_sync_q;
  logic                  rst_n;
  cal_time_t             live, pattern;
  logic [NUM_FIELDS-1:0] fmask;
  logic                  arm, ien, frc, raw;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  always_comb begin
    live.year  = now_year_i;
    live.month = now_month_i;
    live.day   = now_day_i;
    live.wday  = now_wday_i;
    live.hour  = now_hour_i;
    live.min   = now_min_i;
    live.sec   = now_sec_i;
  end

  cal_alarm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk_i),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .wr_sel  (wr_sel_i),
    .wr_data (wr_data_i),
    .pattern (pattern),
    .fmask   (fmask),
    .arm     (arm),
    .ien     (ien),
    .frc     (frc)
  );

  cal_alarm_cmp u_cmp (
    .clk     (clk_i),
    .rst_n   (rst_n),
    .live    (live),
    .pattern (pattern),
    .fmask   (fmask),
    .arm     (arm),
    .raw     (raw)
  );

  cal_alarm_irq_out u_irq (
    .clk   (clk_i),
    .rst_n (rst_n),
    .raw   (raw),
    .ien   (ien),
    .frc   (frc),
    .irq   (irq_o)
  );

  assign match_active_o = arm;
  assign irq_raw_o      = raw;

  // R1: outputs held low while in reset
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_n |=> (!irq_o && !irq_raw_o && !match_active_o));

endmodule

// File: tb/cal_alarm_irq_tb_top.sv
module cal_alarm_irq_tb_top;
  import cal_alarm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  cal_time_t   live;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic        match_active, irq_raw, irq;

  int n_chk = 0;
  int n_bad = 0;

  localparam cal_time_t PAT = '{year: 12'd2024, month: 4'd2, day: 5'd29, wday: 3'd4,
                                hour: 5'd23, min: 6'd59, sec: 6'd58};

  always #4 clk = ~clk;

  cal_alarm_irq dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .now_year_i (live.year), .now_month_i (live.month), .now_day_i (live.day),
    .now_wday_i (live.wday), .now_hour_i (live.hour), .now_min_i (live.min),
    .now_sec_i (live.sec),
    .wr_en_i (wr_en), .wr_sel_i (wr_sel), .wr_data_i (wr_data),
    .match_active_o (match_active), .irq_raw_o (irq_raw), .irq_o (irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] date_word(input cal_time_t t);
    return (32'(t.year) << 16) | (32'(t.month) << 8) | 32'(t.day);
  endfunction

  function automatic logic [31:0] time_word(input cal_time_t t);
    return (32'(t.wday) << 24) | (32'(t.sec) << 16) | (32'(t.min) << 8) | 32'(t.hour);
  endfunction

  // flip the low bit of field f only
  function automatic cal_time_t flip_field(input cal_time_t t, input int f);
    cal_time_t r;
    r = t;
    case (f)
      0: r.sec[0]   = ~r.sec[0];
      1: r.min[0]   = ~r.min[0];
      2: r.hour[0]  = ~r.hour[0];
      3: r.wday[0]  = ~r.wday[0];
      4: r.day[0]   = ~r.day[0];
      5: r.month[0] = ~r.month[0];
      default: r.year[0] = ~r.year[0];
    endcase
    return r;
  endfunction

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; live = PAT;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 match_active", match_active, 1'b0);
    check("R1 irq_raw", irq_raw, 1'b0);
    check("R1 irq", irq, 1'b0);
  endtask

  task automatic t_arm_timing();
    wr(SEL_ARM, 32'd1);
    check("R2 active after arm", match_active, 1'b1);
    check("R5 raw not yet", irq_raw, 1'b0);
    @(negedge clk);
    check("R5 empty mask matches", irq_raw, 1'b1);
    repeat (4) @(negedge clk);
    check("R5 still matching", irq_raw, 1'b1);
    wr(SEL_ARM, 32'd0);
    check("R2 inactive after disarm", match_active, 1'b0);
    @(negedge clk);
    check("R8 raw low after disarm", irq_raw, 1'b0);
  endtask

  task automatic t_full_match();
    wr(SEL_DATE, date_word(PAT));
    wr(SEL_TIME, time_word(PAT));
    wr(SEL_MASK, 32'h7f);
    live = PAT;
    settle();
    check("R8 full match disarmed", irq_raw, 1'b0);
    wr(SEL_ARM, 32'd1);
    @(negedge clk);
    check("R3 R9 full match", irq_raw, 1'b1);
    live = flip_field(PAT, 0);
    @(negedge clk);
    check("R3 second differs", irq_raw, 1'b0);
    live = PAT;
    @(negedge clk);
    check("R3 match again", irq_raw, 1'b1);
    wr(SEL_ARM, 32'd0);
  endtask

  task automatic t_field_mask();
    for (int f = 0; f < NUM_FIELDS; f++) begin
      wr(SEL_ARM, 32'd0);
      live = flip_field(PAT, f);
      wr(SEL_MASK, 32'd1 << f);
      wr(SEL_ARM, 32'd1);
      settle();
      check($sformatf("R4 only field %0d enabled", f), irq_raw, 1'b0);
      wr(SEL_ARM, 32'd0);
      wr(SEL_MASK, 32'h7f & ~(32'd1 << f));
      wr(SEL_ARM, 32'd1);
      settle();
      check($sformatf("R4 field %0d ignored", f), irq_raw, 1'b1);
    end
    wr(SEL_ARM, 32'd0);
    live = PAT;
  endtask

  task automatic t_lock();
    wr(SEL_MASK, 32'h00);
    wr(SEL_ARM, 32'd1);
    wr(SEL_MASK, 32'h7f);
    wr(SEL_TIME, time_word(flip_field(PAT, 1)));
    settle();
    check("R6 writes ignored while armed", irq_raw, 1'b1);
    wr(SEL_ARM, 32'd0);
    wr(SEL_MASK, 32'h7f);
    wr(SEL_TIME, time_word(flip_field(PAT, 1)));
    wr(SEL_ARM, 32'd1);
    settle();
    check("R6 writes applied when disarmed", irq_raw, 1'b0);
    wr(SEL_ARM, 32'd0);
    wr(SEL_TIME, time_word(PAT));
  endtask

  task automatic t_irq();
    wr(SEL_MASK, 32'h00);
    wr(SEL_ARM, 32'd1);
    settle();
    check("R7 raw without enable", irq, 1'b0);
    wr(SEL_IEN, 32'd1);
    check("R7 enable one cycle later", irq, 1'b0);
    @(negedge clk);
    check("R7 enabled irq", irq, 1'b1);
    wr(SEL_IEN, 32'd0);
    @(negedge clk);
    check("R7 disabled irq", irq, 1'b0);
    wr(SEL_ARM, 32'd0);
    settle();
    wr(SEL_FRC, 32'd1);
    check("R7 force one cycle later", irq, 1'b0);
    @(negedge clk);
    check("R7 forced irq", irq, 1'b1);
    wr(SEL_FRC, 32'd0);
    @(negedge clk);
    check("R7 force released", irq, 1'b0);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    t_reset();
    t_arm_timing();
    t_full_match();
    t_field_mask();
    t_lock();
    t_irq();
    report();
  end

endmodule